// File: doc/BRIEF.md
# Display Line Scan Pointer

This block supplies the display-RAM row address of the line currently being shifted out to the segment drivers. A host command loads a start-line register, which names the RAM row that appears on the first common line. Each time the frame signal changes level, in either direction, the line counter is reloaded from that register. Each line clock then moves it on by one row.

Writing a different start line makes the visible image scroll vertically, and the new value takes effect at the next frame boundary. The frame and line-clock inputs are assumed to be synchronous to the system clock already. Their edges are detected against a one-cycle history, and the row pointer is held in a register.

Top module: `line_scan_ptr`

## Requirements
- R1: While reset is high, the row pointer and the start-line register are cleared to 0. A frame edge after reset with no write therefore yields row 0.
- R2: When `start_wr` is high at a clock edge, the start-line register takes `start_data`. The row pointer does not change because of the write.
- R3: A rising edge of `frame_in` (0 in the previous cycle, 1 now) makes the row pointer equal the start-line register on the next clock edge.
- R4: A falling edge of `frame_in` (1 in the previous cycle, 0 now) reloads the row pointer in the same way as R3.
- R5: A rising edge of `line_clk_in` with no frame edge increments the row pointer by exactly 1 on that clock edge.
- R6: The row pointer is `ROW_W` bits wide (5 by default, 32 rows) and wraps from 31 to 0.
- R7: If a frame edge and a line-clock rising edge fall in the same cycle, the reload wins. The pointer becomes the start line, not the start line plus 1.
- R8: If `line_clk_in` is held high, falls, or stays low, and `frame_in` is constant, the row pointer holds its value.
- R9: If a start-line write and a frame edge fall in the same cycle, the reload uses the value the register held before the write. The written value appears at the following frame edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_wr | input | 1 | Start-line write strobe |
| start_data | input | ROW_W | Start-line value to store |
| frame_in | input | 1 | Synchronised frame signal; both edges start a frame |
| line_clk_in | input | 1 | Synchronised line clock; the rising edge advances one line |
| row_ptr | output | ROW_W | Registered RAM row of the current display line |

## Verification
Two functions can land in the same cycle: a frame-boundary reload and a line-clock advance. The same holds for a reload and a start-line write. The bench toggles `frame_in` and raises `line_clk_in` in one cycle, and expects the pointer to equal the stored start line rather than one past it. It also toggles the frame in the cycle where a new start line is written, and expects the older value first and the new one only at the next frame edge. Every start value is swept through a full wrap with expected rows computed modulo 32.

// File: rtl/lsp_pkg.sv
package lsp_pkg;
  localparam int LSP_ROW_W_DEF = 5;

  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_ANY  = 1'b1
  } edge_mode_e;
endpackage

// File: rtl/lsp_edge_det.sv
module lsp_edge_det
  import lsp_pkg::*;
#(
  parameter edge_mode_e MODE = EDGE_RISE
) (
  input  logic clk,
  input  logic rst,
  input  logic sig_in,
  output logic hit
);
  logic prev_q;

  // History follows the input during reset so no false edge appears on release.
  always_ff @(posedge clk) begin
    prev_q <= sig_in;
  end

  generate
    if (MODE == EDGE_ANY) begin : g_any
      always_comb hit = !rst && (sig_in ^ prev_q);
    end else begin : g_rise
      always_comb hit = !rst && (sig_in && !prev_q);
    end
  endgenerate
endmodule

// File: rtl/lsp_start_reg.sv
module lsp_start_reg #(
  parameter int ROW_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [ROW_W-1:0] wr_data,
  output logic [ROW_W-1:0] value_q
);
  always_ff @(posedge clk) begin
    if (rst)        value_q <= '0;
    else if (wr_en) value_q <= wr_data;
  end
endmodule

// File: rtl/lsp_line_ctr.sv
module lsp_line_ctr #(
  parameter int ROW_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reload,
  input  logic             step,
  input  logic [ROW_W-1:0] load_val,
  output logic [ROW_W-1:0] count_q
);
  localparam logic [ROW_W-1:0] ONE = ROW_W'(1);

  // Reload outranks step; the add wraps naturally at the width.
  always_ff @(posedge clk) begin
    if (rst)         count_q <= '0;
    else if (reload) count_q <= load_val;
    else if (step)   count_q <= count_q + ONE;
  end
endmodule

// File: rtl/line_scan_ptr.sv
module line_scan_ptr
  import lsp_pkg::*;
#(
  parameter int ROW_W = LSP_ROW_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_wr,
  input  logic [ROW_W-1:0] start_data,
  input  logic             frame_in,
  input  logic             line_clk_in,
  output logic [ROW_W-1:0] row_ptr
);
  logic             frame_hit;
  logic             line_hit;
  logic [ROW_W-1:0] start_line_q;

  lsp_edge_det #(.MODE(EDGE_ANY)) u_frame_edge (
    .clk(clk), .rst(rst), .sig_in(frame_in), .hit(frame_hit)
  );

  lsp_edge_det #(.MODE(EDGE_RISE)) u_line_edge (
    .clk(clk), .rst(rst), .sig_in(line_clk_in), .hit(line_hit)
  );

  lsp_start_reg #(.ROW_W(ROW_W)) u_start (
    .clk(clk), .rst(rst), .wr_en(start_wr), .wr_data(start_data),
    .value_q(start_line_q)
  );

  lsp_line_ctr #(.ROW_W(ROW_W)) u_ctr (
    .clk(clk), .rst(rst), .reload(frame_hit), .step(line_hit),
    .load_val(start_line_q), .count_q(row_ptr)
  );
endmodule

// File: rtl/line_scan_ptr_chk.sv
module line_scan_ptr_chk #(
  parameter int ROW_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             start_wr,
  input logic [ROW_W-1:0] start_data,
  input logic             frame_in,
  input logic             line_clk_in,
  input logic [ROW_W-1:0] row_ptr,
  input logic [ROW_W-1:0] start_line_q
);
  logic f_prev, l_prev;
  always_ff @(posedge clk) begin
    f_prev <= frame_in;
    l_prev <= line_clk_in;
  end

  logic f_edge, l_rise;
  assign f_edge = (frame_in != f_prev);
  assign l_rise = line_clk_in && !l_prev;

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (row_ptr == '0 && start_line_q == '0));

  assert_start_store_R2: assert property (@(posedge clk) disable iff (rst)
    start_wr |=> start_line_q == $past(start_data));

  // Covers both rising (R3) and falling (R4) frame edges.
  assert_frame_reload_R3: assert property (@(posedge clk) disable iff (rst)
    f_edge |=> row_ptr == $past(start_line_q));

  assert_falling_reload_R4: assert property (@(posedge clk) disable iff (rst)
    (f_prev && !frame_in) |=> row_ptr == $past(start_line_q));

  assert_line_step_R5: assert property (@(posedge clk) disable iff (rst)
    (!f_edge && l_rise) |=> row_ptr == ROW_W'($past(row_ptr) + 1'b1));

  assert_reload_wins_R7: assert property (@(posedge clk) disable iff (rst)
    (f_edge && l_rise) |=> row_ptr == $past(start_line_q));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!f_edge && !l_rise) |=> $stable(row_ptr));
endmodule

bind line_scan_ptr line_scan_ptr_chk #(.ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst(rst), .start_wr(start_wr), .start_data(start_data),
  .frame_in(frame_in), .line_clk_in(line_clk_in), .row_ptr(row_ptr),
  .start_line_q(start_line_q)
);

// File: tb/sim_line_scan_ptr.sv
`timescale 1ns/1ps
module sim_line_scan_ptr;
  localparam int W = 5;
  localparam int ROWS = 1 << W;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start_wr = 1'b0;
  logic [W-1:0] start_data = '0;
  logic         frame_in = 1'b0;
  logic         line_clk_in = 1'b0;
  logic [W-1:0] row_ptr;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  line_scan_ptr #(.ROW_W(W)) u0 (
    .clk(clk), .rst(rst), .start_wr(start_wr), .start_data(start_data),
    .frame_in(frame_in), .line_clk_in(line_clk_in), .row_ptr(row_ptr)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int exp);
    total++;
    if (int'(row_ptr) != exp) begin
      bad++;
      $display("FAIL %s: row_ptr=%0d expected=%0d", req, row_ptr, exp);
    end
  endtask

  task automatic write_start(input int v);
    start_wr = 1'b1; start_data = W'(v);
    tick();
    start_wr = 1'b0;
  endtask

  task automatic flip_frame();
    frame_in = ~frame_in;
    tick();
  endtask

  task automatic line_pulse();
    line_clk_in = 1'b1;
    tick();
    line_clk_in = 1'b0;
    tick();
  endtask

  initial begin : watchdog
    #400000;
    bad++; total++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int exp;
    tick(); tick();
    check("R1 reset value", 0);
    rst = 1'b0;
    tick();
    flip_frame();
    check("R1 start register cleared", 0);

    // R3/R4/R5/R6: every start value, alternating frame edge direction, full wrap.
    for (int s = 0; s < ROWS; s++) begin
      write_start(s);
      check("R2 write leaves pointer", exp_after_prev(s));
      flip_frame();
      check(frame_in ? "R3 rising reload" : "R4 falling reload", s);
      for (int k = 1; k <= ROWS + 1; k++) begin
        line_pulse();
        check((s + k) % ROWS == 0 ? "R6 wrap" : "R5 step", (s + k) % ROWS);
      end
    end
    exp = (ROWS - 1 + ROWS + 1) % ROWS;

    // R8: line clock held high, falling, and low: no motion.
    line_clk_in = 1'b1; tick();
    exp = (exp + 1) % ROWS;
    check("R5 step before hold", exp);
    for (int i = 0; i < 4; i++) begin
      tick();
      check("R8 held high", exp);
    end
    line_clk_in = 1'b0; tick();
    check("R8 falling edge", exp);
    for (int i = 0; i < 3; i++) begin
      tick();
      check("R8 idle", exp);
    end

    // R7: frame edge and line clock rise together.
    write_start(9);
    frame_in = ~frame_in; line_clk_in = 1'b1;
    tick();
    check("R7 reload beats step", 9);
    line_clk_in = 1'b0; tick();
    frame_in = ~frame_in; line_clk_in = 1'b1;
    tick();
    check("R7 reload beats step other edge", 9);
    line_clk_in = 1'b0; tick();

    // R9: write and frame edge together.
    write_start(4);
    flip_frame();
    check("R9 baseline", 4);
    start_wr = 1'b1; start_data = W'(20); frame_in = ~frame_in;
    tick();
    start_wr = 1'b0;
    check("R9 old value used", 4);
    flip_frame();
    check("R9 new value next frame", 20);

    // R1: reset mid-run clears both.
    rst = 1'b1; tick(); tick();
    check("R1 mid-run reset", 0);
    rst = 1'b0; tick();
    flip_frame();
    check("R1 start cleared by reset", 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // Pointer value expected just after the write of start s in the sweep.
  function automatic int exp_after_prev(input int s);
    if (s == 0) return 0;
    return (s - 1 + ROWS + 1) % ROWS;
  endfunction
endmodule